// File: doc/BRIEF.md
# Read Strobe Sequencer with Minimum-Width Hold

This block issues single reads to an external device whose read strobe must stay asserted longer than one period of the local clock. A one-cycle read command, taken while the block is idle, raises the read-request output and keeps it high for a fixed number of clock cycles. That number comes from two parameters: the clock period and the minimum strobe width, both in picoseconds. A reloadable down-counter inside the single asserting state measures the hold, so the state machine needs no chain of wait states. The same code therefore works with a slower device or a different clock rate once the two timing parameters are changed.

On the last cycle of the hold, the block captures the device's data bus into an output register and drops the strobe. A one-cycle data-valid pulse marks the new word. While a read is in progress the block reports busy, and any further command is discarded.

Top module: `rdstb_ctrl`

## Requirements
- R1: The hold length in cycles is HOLD = ceil(MIN_PULSE_PS / CLK_PERIOD_PS), and at least 1. With the defaults (37037 ps, 50000 ps) HOLD is 2. With 130000 ps it is 4, and with 20000 ps it is 1.
- R2: An accepted command (rd_cmd high at a rising edge while idle) raises rd_req from the next cycle on. rd_req then stays high for exactly HOLD consecutive cycles.
- R3: data_out takes the value that rd_data_in has during the last cycle in which rd_req is high.
- R4: data_valid is high for exactly one cycle per completed read, in the first cycle after rd_req drops.
- R5: busy is high exactly while rd_req is high.
- R6: rd_cmd sampled while busy is ignored: it neither lengthens the current strobe nor starts a second read.
- R7: A command presented in the cycle in which data_valid is high is accepted. The new strobe follows with no idle gap and again lasts HOLD cycles, because the counter reloads on every entry to the asserting state.
- R8: Reset is synchronous and active high. It clears rd_req, busy, data_valid and data_out at the next edge, including in the middle of a read, and the aborted read produces no data_valid.
- R9: data_out keeps its value between reads, whatever rd_data_in does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_cmd | input | 1 | Read command, sampled at the rising edge |
| rd_data_in | input | DATA_W | Data bus from the device |
| rd_req | output | 1 | Read strobe to the device |
| busy | output | 1 | A read is in progress |
| data_valid | output | 1 | One-cycle pulse marking fresh data_out |
| data_out | output | DATA_W | Captured read data |

## Verification
On every cycle, the assertions check that each strobe lasts exactly HOLD cycles (counted by a counter in the checker), that a strobe rises only after a command seen while idle, and that data_valid is a single pulse tied to the falling strobe. They also check that busy tracks the strobe and that reset clears the outputs. Only the bench scenarios can show which bus word is captured and that it then stays put. They also show that the parameter arithmetic yields the right widths for three different timings, and that a command in the valid cycle chains straight into a new read.

// File: rtl/rdstb_pkg.sv
package rdstb_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } rd_state_e;

    typedef struct packed {
        logic start;    // load counter, enter hold
        logic capture;  // sample device bus, leave hold
    } seq_ctl_t;

    function automatic int unsigned hold_cycles(input int unsigned period_ps,
                                                input int unsigned min_ps);
        int unsigned c;
        c = (min_ps + period_ps - 1) / period_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned hold);
        return (hold > 1) ? $clog2(hold) : 1;
    endfunction

endpackage

// File: rtl/rdstb_hold_counter.sv
module rdstb_hold_counter #(
    parameter int unsigned HOLD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic last
);
    import rdstb_pkg::*;

    localparam int unsigned CNT_W = cnt_width(HOLD);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= RELOAD;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/rdstb_fsm.sv
module rdstb_fsm (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_cmd,
    input  logic                  last,
    output rdstb_pkg::rd_state_e  state,
    output rdstb_pkg::seq_ctl_t   ctl
);
    import rdstb_pkg::*;

    rd_state_e state_q, state_d;

    always_comb begin
        state_d     = state_q;
        ctl.start   = 1'b0;
        ctl.capture = 1'b0;
        unique case (state_q)
            ST_IDLE: if (rd_cmd) begin
                state_d   = ST_HOLD;
                ctl.start = 1'b1;
            end
            ST_HOLD: if (last) begin
                state_d     = ST_IDLE;
                ctl.capture = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/rdstb_capture.sv
module rdstb_capture #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= capture;
            if (capture) dout <= din;
        end
    end
endmodule

// File: rtl/rdstb_ctrl.sv
module rdstb_ctrl #(
    parameter int unsigned CLK_PERIOD_PS = 37037,
    parameter int unsigned MIN_PULSE_PS  = 50000,
    parameter int unsigned DATA_W        = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_cmd,
    input  logic [DATA_W-1:0] rd_data_in,
    output logic              rd_req,
    output logic              busy,
    output logic              data_valid,
    output logic [DATA_W-1:0] data_out
);
    import rdstb_pkg::*;

    localparam int unsigned HOLD = hold_cycles(CLK_PERIOD_PS, MIN_PULSE_PS);

    rd_state_e state;
    seq_ctl_t  ctl;
    logic      last;
    logic      in_hold;

    assign in_hold = (state == ST_HOLD);

    rdstb_fsm fsm_i (
        .clk    (clk),
        .rst    (rst),
        .rd_cmd (rd_cmd),
        .last   (last),
        .state  (state),
        .ctl    (ctl)
    );

    rdstb_hold_counter #(.HOLD(HOLD)) cnt_i (
        .clk  (clk),
        .rst  (rst),
        .load (ctl.start),
        .run  (in_hold),
        .last (last)
    );

    rdstb_capture #(.DATA_W(DATA_W)) cap_i (
        .clk     (clk),
        .rst     (rst),
        .capture (ctl.capture),
        .din     (rd_data_in),
        .dout    (data_out),
        .valid   (data_valid)
    );

    assign rd_req = in_hold;
    assign busy   = in_hold;
endmodule

// File: rtl/rdstb_ctrl_chk.sv
module rdstb_ctrl_chk #(
    parameter int unsigned CLK_PERIOD_PS = 37037,
    parameter int unsigned MIN_PULSE_PS  = 50000,
    parameter int unsigned DATA_W        = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_cmd,
    input logic              rd_req,
    input logic              busy,
    input logic              data_valid,
    input logic [DATA_W-1:0] data_out
);
    import rdstb_pkg::*;

    localparam int unsigned HOLD = hold_cycles(CLK_PERIOD_PS, MIN_PULSE_PS);

    int unsigned hold_len;

    always_ff @(posedge clk) begin
        if (rst)         hold_len <= 0;
        else if (rd_req) hold_len <= hold_len + 1;
        else             hold_len <= 0;
    end

    // R2: every strobe spans exactly HOLD cycles
    a_r2_strobe_width: assert property (@(posedge clk) disable iff (rst)
        ($fell(rd_req) && !$past(rst)) |-> (hold_len == HOLD));

    a_r2_no_overrun: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (hold_len < HOLD));

    // R4: single-cycle valid, right after the strobe drops
    a_r4_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        data_valid |=> !data_valid);

    a_r4_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> (!rd_req && $past(rd_req)));

    // R5: busy mirrors the strobe
    a_r5_busy_tracks: assert property (@(posedge clk) disable iff (rst)
        busy == rd_req);

    // R6: a strobe starts only from idle with a command
    a_r6_start_from_idle: assert property (@(posedge clk) disable iff (rst)
        ($rose(rd_req) && !$past(rst)) |-> ($past(rd_cmd) && !$past(busy)));

    // R8: reset clears the outputs at the next edge
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (!rd_req && !busy && !data_valid && data_out == '0));
endmodule

bind rdstb_ctrl rdstb_ctrl_chk #(
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .MIN_PULSE_PS  (MIN_PULSE_PS),
    .DATA_W        (DATA_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .rd_cmd     (rd_cmd),
    .rd_req     (rd_req),
    .busy       (busy),
    .data_valid (data_valid),
    .data_out   (data_out)
);

// File: tb/rdstb_ctrl_tb_top.sv
module rdstb_ctrl_tb_top;
    localparam int DW      = 16;
    localparam int EXP_H   = (50000 + 37037 - 1) / 37037;   // 2
    localparam int EXP_W   = (130000 + 37037 - 1) / 37037;  // 4
    localparam int EXP_N   = 1;                             // 20000 ps < period

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_cmd = 1'b0, cmd_w = 1'b0, cmd_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic rd_req, busy, data_valid;
    logic [DW-1:0] data_out;
    logic req_w, busy_w, val_w, req_n, busy_n, val_n;
    logic [DW-1:0] dout_w, dout_n;

    int tests = 0, fails = 0;

    always #4 clk = ~clk;  // 125 MHz

    rdstb_ctrl #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .rd_data_in(din),
        .rd_req(rd_req), .busy(busy), .data_valid(data_valid), .data_out(data_out));

    rdstb_ctrl #(.MIN_PULSE_PS(130000), .DATA_W(DW)) dut_w_i (
        .clk(clk), .rst(rst), .rd_cmd(cmd_w), .rd_data_in(din),
        .rd_req(req_w), .busy(busy_w), .data_valid(val_w), .data_out(dout_w));

    rdstb_ctrl #(.MIN_PULSE_PS(20000), .DATA_W(DW)) dut_n_i (
        .clk(clk), .rst(rst), .rd_cmd(cmd_n), .rd_data_in(din),
        .rd_req(req_n), .busy(busy_n), .data_valid(val_n), .data_out(dout_n));

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Issue a command at negedge, then follow the strobe. Each hold cycle
    // gets base+n on the bus; returns strobe width.
    task automatic run_read(input logic [DW-1:0] base, input bit keep_cmd,
                            output int width);
        width = 0;
        rd_cmd = 1'b1;
        @(negedge clk);
        if (!keep_cmd) rd_cmd = 1'b0;
        for (int i = 0; i < 20 && rd_req; i++) begin
            width++;
            check("R5 busy during strobe", busy, 1);
            din = base + DW'(width);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R8 rd_req after reset", rd_req, 0);
        check("R8 busy after reset", busy, 0);
        check("R8 data_valid after reset", data_valid, 0);
        check("R8 data_out after reset", data_out, 0);
    endtask

    task automatic t_single();
        int w;
        run_read(16'h1000, 1'b0, w);
        check("R1/R2 default strobe width", w, EXP_H);
        check("R4 valid after strobe", data_valid, 1);
        check("R5 busy low after strobe", busy, 0);
        check("R3 captured word", data_out, 16'h1000 + EXP_H);
        @(negedge clk);
        check("R4 valid lasts one cycle", data_valid, 0);
    endtask

    task automatic t_ignore();
        int w = 0;
        rd_cmd = 1'b1;
        @(negedge clk);
        rd_cmd = 1'b1;  // sampled while busy: must be ignored (R6)
        for (int i = 0; i < 20 && rd_req; i++) begin
            w++;
            din = 16'h2000 + DW'(w);
            @(negedge clk);
            rd_cmd = 1'b0;
        end
        check("R6 width unchanged by busy cmd", w, EXP_H);
        check("R6 data_valid", data_valid, 1);
        check("R6 no second strobe", rd_req, 0);
        @(negedge clk);
        check("R6 still idle", rd_req, 0);
        check("R3 word with ignored cmd", data_out, 16'h2000 + EXP_H);
    endtask

    task automatic t_back2back();
        int w1, w2;
        run_read(16'h3000, 1'b0, w1);
        check("R7 first strobe width", w1, EXP_H);
        check("R7 valid cycle", data_valid, 1);
        run_read(16'h3100, 1'b0, w2);  // command in the valid cycle
        check("R7 chained strobe width", w2, EXP_H);
        check("R7 chained word", data_out, 16'h3100 + EXP_H);
    endtask

    task automatic t_hold_data();
        logic [DW-1:0] keep;
        keep = data_out;
        for (int i = 0; i < 5; i++) begin
            din = DW'(16'hBEE0 + i);
            @(negedge clk);
            check("R9 data_out stable", data_out, keep);
        end
    endtask

    task automatic t_reset_mid();
        rd_cmd = 1'b1;
        @(negedge clk);
        rd_cmd = 1'b0;
        check("R8 strobe started", rd_req, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8 strobe cut by reset", rd_req, 0);
        check("R8 busy cut by reset", busy, 0);
        check("R8 data_out cleared", data_out, 0);
        @(negedge clk);
        check("R8 no valid after abort", data_valid, 0);
        check("R8 stays idle", rd_req, 0);
    endtask

    task automatic t_widths();
        int ww = 0, wn = 0;
        cmd_w = 1'b1; cmd_n = 1'b1;
        @(negedge clk);
        cmd_w = 1'b0; cmd_n = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (req_w) ww++;
            if (req_n) wn++;
            @(negedge clk);
        end
        check("R1 wide strobe width", ww, EXP_W);
        check("R1 narrow strobe width", wn, EXP_N);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_ignore();
        t_back2back();
        t_hold_data();
        t_reset_mid();
        t_widths();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 20000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule